// File: doc/BRIEF.md
# Selectable-Trigger Interrupt Aggregator

This block gathers fifteen interrupt request lines from peripherals into one host interrupt. Each request line passes through a two-flop synchronizer. Software then decides, source by source, whether the line is treated as a level or as a rising edge. Level sources make their status bit follow the synchronized line. Edge sources set a sticky status bit that stays set until software clears it. A per-source enable mask and a global enable decide which pending bits reach the host interrupt pin.

Software reaches the block through a simple 32-bit register bus. Writes are single-cycle strobes and reads are combinational from the word address. The bus has four words:

| Offset | Word | Access |
|---|---|---|
| 0x0 | Latched status | read-only; a write clears bits |
| 0x4 | Trigger mode | write-only |
| 0x8 | Enable | read/write |
| 0xC | Live synchronized request lines | read-only |

A status read also carries a summary bit. It is set whenever any enabled source is pending, whether or not the global enable is on. Priority encoding and vectoring are left to the host.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, the status, mode and enable registers are all 0. The irq_o output is low, and reads of offsets 0x0, 0x8 and 0xC return 0 while all request lines are low.
- R2: The word at offset 0x4 (trigger mode) is write-only and reads as 0. A write to offset 0xC has no effect. Bits 31..16 of every read are 0.
- R3: Offset 0xC bits 14..0 show request lines 14..0 after a two-flop synchronizer. A change on a request line appears there two clock edges after it is driven.
- R4: A source whose mode bit is 0 (level) has a status bit equal to its synchronized line one cycle later. It therefore changes three clock edges after the input, and a clear write has no lasting effect on it.
- R5: A source whose mode bit is 1 (rising edge) has its status bit set three clock edges after a rising edge on its request line. A request pulse of a single cycle is enough. The bit stays set after the line falls, and a falling edge never sets it.
- R6: Writing offset 0x0 clears, in the edge-mode sources, exactly the status bits written as 1. Bits written as 0 keep their value.
- R7: When a rising edge and a clear of the same edge-mode bit land in the same cycle, the bit stays set.
- R8: Status bit 15 reads 1 exactly when, for some source i, status bit i and enable bit i are both 1. The global enable (enable bit 15) has no influence on it.
- R9: irq_o is high exactly when enable bit 15 is 1 and status bit 15 would read 1.
- R10: A write to offset 0x8 stores bits 15..0. Bits 14..0 are the per-source enables and bit 15 is the global enable. The stored value reads back at offset 0x8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | 15 | Asynchronous request lines, one per source |
| bus_wr_en | input | 1 | Single-cycle write strobe |
| bus_addr | input | 4 | Byte offset of the register; bits 3..2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Host interrupt request |

## Verification
The sharpest corner is a clear that lands in the same cycle as a new rising edge. A design that lets the clear win would silently lose an interrupt, and the bench catches that by a status read of 0 where the bit should still be set. Single-cycle request pulses check that edges are taken after the synchronizer and held. A design that sampled the line as a level, or reacted to the falling edge, would show a status of 0, or a bit set after the line dropped.

The bench also checks that the summary bit ignores the global enable while irq_o honours it. A design that put the gate in the wrong place would show the mismatch on one of the two. Partial clears check that a 0 in the clear word does not disturb a neighbouring bit. Level sources are checked to ignore clears and to follow the line with exactly three edges of delay.

// File: rtl/irq_agg_pkg.sv
`timescale 1ns/1ps
package irq_agg_pkg;
  localparam int unsigned BUS_W = 32;

  // Word select, taken from address bits 3..2.
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_MODE   = 2'd1,
    SEL_ENABLE = 2'd2,
    SEL_RAW    = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_sync.sv
`timescale 1ns/1ps
module irq_sync #(
  parameter int unsigned WIDTH  = 15,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) begin
        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_capture.sv
`timescale 1ns/1ps
module irq_capture #(
  parameter int unsigned N = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sync_i,
  input  logic [N-1:0] mode_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] stat_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] stat_q;
  logic [N-1:0] stat_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_i;
  end

  assign rise_o = sync_i & ~prev_q;

  // Per source: level mode tracks the line; edge mode is sticky, and a new
  // edge wins over a clear that lands in the same cycle.
  for (genvar i = 0; i < N; i++) begin : g_src
    assign stat_d[i] = mode_i[i] ? (rise_o[i] | (stat_q[i] & ~clr_i[i]))
                                 : sync_i[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/irq_regs.sv
`timescale 1ns/1ps
module irq_regs
  import irq_agg_pkg::*;
#(
  parameter int unsigned N      = 15,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic [N-1:0]      stat_i,
  input  logic [N-1:0]      raw_i,
  input  logic              summary_i,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [N-1:0]      mode_o,
  output logic [N:0]        en_o,
  output logic [N-1:0]      clr_o
);
  reg_sel_e     sel;
  logic [N-1:0] mode_q;
  logic [N:0]   en_q;

  assign sel   = reg_sel_e'(bus_addr[3:2]);
  assign clr_o = (bus_wr_en && sel == SEL_STATUS) ? bus_wdata[N-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      en_q   <= '0;
    end else if (bus_wr_en) begin
      if (sel == SEL_MODE)   mode_q <= bus_wdata[N-1:0];
      if (sel == SEL_ENABLE) en_q   <= bus_wdata[N:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      SEL_STATUS: begin
        bus_rdata[N-1:0] = stat_i;
        bus_rdata[N]     = summary_i;
      end
      SEL_MODE:   bus_rdata = '0;
      SEL_ENABLE: bus_rdata[N:0] = en_q;
      SEL_RAW:    bus_rdata[N-1:0] = raw_i;
      default:    bus_rdata = '0;
    endcase
  end

  assign mode_o = mode_q;
  assign en_o   = en_q;
endmodule

// File: rtl/irq_aggregator.sv
`timescale 1ns/1ps
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_SRC       = 15,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_req_i,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq_o
);
  logic [N_SRC-1:0] sync_q;
  logic [N_SRC-1:0] rise;
  logic [N_SRC-1:0] stat_q;
  logic [N_SRC-1:0] mode_q;
  logic [N_SRC:0]   en_q;
  logic [N_SRC-1:0] clr_mask;
  logic             pending;

  irq_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(irq_req_i), .sync_o(sync_q)
  );

  irq_capture #(.N(N_SRC)) u_cap (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_q), .mode_i(mode_q),
    .clr_i(clr_mask), .rise_o(rise), .stat_o(stat_q)
  );

  irq_regs #(.N(N_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .stat_i(stat_q), .raw_i(sync_q),
    .summary_i(pending), .bus_rdata(bus_rdata), .mode_o(mode_q),
    .en_o(en_q), .clr_o(clr_mask)
  );

  assign pending = |(stat_q & en_q[N_SRC-1:0]);
  assign irq_o   = en_q[N_SRC] & pending;
endmodule

// File: rtl/irq_aggregator_chk.sv
`timescale 1ns/1ps
module irq_aggregator_chk #(
  parameter int unsigned N_SRC  = 15,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       bus_rdata,
  input logic              irq_o,
  input logic [N_SRC-1:0]  sync_q,
  input logic [N_SRC-1:0]  rise,
  input logic [N_SRC-1:0]  stat_q,
  input logic [N_SRC-1:0]  mode_q,
  input logic [N_SRC:0]    en_q,
  input logic [N_SRC-1:0]  clr_mask
);
  // R2: upper read bits are always zero
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[31:N_SRC+1] == '0);

  // R9: no host interrupt without the global enable
  a_r9_needs_global: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[N_SRC] |-> !irq_o);

  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    // R4: level source follows its synchronized line one cycle later
    a_r4_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q[i] |=> (stat_q[i] == $past(sync_q[i])));

    // R5: edge source stays set when not cleared
    a_r5_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[i] && stat_q[i] && !clr_mask[i]) |=> stat_q[i]);

    // R6: clear without a new edge drops the bit
    a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[i] && clr_mask[i] && !rise[i]) |=> !stat_q[i]);

    // R7: an edge wins over a simultaneous clear
    a_r7_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[i] && rise[i]) |=> stat_q[i]);
  end
endmodule

bind irq_aggregator irq_aggregator_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rdata(bus_rdata), .irq_o(irq_o),
  .sync_q(sync_q), .rise(rise), .stat_q(stat_q), .mode_q(mode_q),
  .en_q(en_q), .clr_mask(clr_mask)
);

// File: tb/test_irq_aggregator.sv
`timescale 1ns/1ps
module test_irq_aggregator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] req = '0;
  logic        wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [3:0] A_STAT = 4'h0, A_MODE = 4'h4, A_EN = 4'h8, A_RAW = 4'hC;

  irq_aggregator i_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .irq_req_i(req), .bus_wr_en(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(input logic [3:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic expect_reg(input logic [3:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #1;
    check(rdata === exp, tag, rdata, exp);
  endtask

  task automatic expect_irq(input logic exp, input string tag);
    #1;
    check(irq === exp, tag, {31'b0, irq}, {31'b0, exp});
  endtask

  task automatic t_reset;
    expect_reg(A_STAT, 32'h0, "R1 status after reset");
    expect_reg(A_EN,   32'h0, "R1 enable after reset");
    expect_reg(A_RAW,  32'h0, "R1 raw after reset");
    expect_irq(1'b0, "R1 irq after reset");
  endtask

  task automatic t_raw;
    req = 15'h0089;
    tick(1);
    expect_reg(A_RAW, 32'h0, "R3 raw one edge later");
    tick(1);
    expect_reg(A_RAW, 32'h0089, "R3 raw two edges later");
    req = '0;
    tick(3);
    expect_reg(A_RAW, 32'h0, "R3 raw after drop");
  endtask

  task automatic t_regmap;
    write(A_EN, 32'hFFFF_FFFF);
    expect_reg(A_EN, 32'h0000_FFFF, "R10 enable readback");
    write(A_MODE, 32'h0000_7FFF);
    expect_reg(A_MODE, 32'h0, "R2 mode reads zero");
    write(A_RAW, 32'hFFFF_FFFF);
    expect_reg(A_RAW, 32'h0, "R2 raw write ignored");
    write(A_MODE, 32'h0);
    write(A_EN, 32'h0000_1234);
    expect_reg(A_EN, 32'h0000_1234, "R10 enable second pattern");
    write(A_EN, 32'h0);
  endtask

  task automatic t_level;
    req = 15'h0008;
    tick(2);
    expect_reg(A_STAT, 32'h0, "R4 level not yet");
    tick(1);
    expect_reg(A_STAT, 32'h0008, "R4 level after three edges");
    write(A_STAT, 32'h0008);
    expect_reg(A_STAT, 32'h0008, "R4 clear ignored in level mode");
    write(A_EN, 32'h0000_0008);
    expect_reg(A_STAT, 32'h0000_8008, "R8 summary without global");
    expect_irq(1'b0, "R9 irq gated by global");
    write(A_EN, 32'h0000_8008);
    expect_irq(1'b1, "R9 irq with global");
    req = '0;
    tick(2);
    expect_reg(A_STAT, 32'h0000_8008, "R4 level holds two edges");
    tick(1);
    expect_reg(A_STAT, 32'h0, "R4 level follows drop");
    expect_irq(1'b0, "R9 irq after level drop");
    write(A_EN, 32'h0);
  endtask

  task automatic t_edge;
    write(A_MODE, 32'h0000_4081);
    req = 15'h0081;
    tick(1);
    req = '0;
    tick(5);
    expect_reg(A_STAT, 32'h0000_0081, "R5 pulse latched and held");
    write(A_STAT, 32'h0000_0001);
    expect_reg(A_STAT, 32'h0000_0080, "R6 clear only written ones");
    write(A_STAT, 32'h0000_0080);
    expect_reg(A_STAT, 32'h0, "R6 clear remaining bit");
  endtask

  task automatic t_collide;
    req = 15'h4000;
    tick(1);
    req = '0;
    tick(5);
    expect_reg(A_STAT, 32'h0000_4000, "R5 bit14 latched");
    req = 15'h4000;
    tick(2);
    write(A_STAT, 32'h0000_4000);
    expect_reg(A_STAT, 32'h0000_4000, "R7 edge wins over clear");
    write(A_STAT, 32'h0000_4000);
    expect_reg(A_STAT, 32'h0, "R6 clear with line held high");
    req = '0;
    tick(4);
    expect_reg(A_STAT, 32'h0, "R5 falling edge does not set");
  endtask

  task automatic t_global;
    req = 15'h0001;
    tick(1);
    req = '0;
    tick(5);
    write(A_EN, 32'h0000_0001);
    expect_reg(A_STAT, 32'h0000_8001, "R8 summary set by enabled pending");
    expect_irq(1'b0, "R9 no irq without global");
    write(A_EN, 32'h0000_8001);
    expect_irq(1'b1, "R9 irq with global and source");
    write(A_EN, 32'h0000_8000);
    expect_reg(A_STAT, 32'h0000_0001, "R8 summary clear when source disabled");
    expect_irq(1'b0, "R9 no irq when source disabled");
    write(A_STAT, 32'h0000_0001);
    write(A_EN, 32'h0000_8001);
    expect_reg(A_STAT, 32'h0, "R6 cleared before re-enable");
    expect_irq(1'b0, "R9 no irq after clear");
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_raw();
    t_regmap();
    t_level();
    t_edge();
    t_collide();
    t_global();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule